// File: doc/BRIEF.md
# Branch Decision and Next-PC Unit

This unit resolves control-transfer instructions for a small 16-bit processor with a 1024-word code space. Given the 3-bit subtype of a branch-family instruction, the value of the named register, the value of register zero, the address of the instruction and its 6-bit offset field, it decides whether the flow of execution is redirected. It also produces the address of the next instruction to fetch.

Conditional subtypes compare the named register against register zero, treating both as signed 16-bit integers. A taken conditional branch goes to the instruction address plus the sign-extended offset. The register-jump subtype always redirects to the low address bits of the named register. Anything that does not redirect falls through to the instruction address plus one. Every next-PC value wraps modulo the code space. Malformed encodings are flagged and never redirect. The three results are registered, so they appear one clock after the inputs are presented.

Top module: `bru_unit`

## Requirements
- R1: Subtype 000 (register jump) with an all-zero offset field is always taken, and its next PC is bits [9:0] of the register value.
- R2: Subtype 001 is taken when the register equals register zero. Subtype 010 is taken when they differ.
- R3: Subtype 011 is taken when the register is signed-less than register zero. Subtype 100 is taken when it is signed-greater.
- R4: Subtype 101 is taken on signed less-or-equal. Subtype 110 is taken on signed greater-or-equal.
- R5: A taken conditional branch sets the next PC to the instruction address plus the two's-complement offset field (range -32..31), modulo 1024.
- R6: When the branch is not taken, the next PC is the instruction address plus one, modulo 1024.
- R7: Subtype 111 raises the invalid flag, is never taken, and produces the fall-through next PC.
- R8: Subtype 000 with a non-zero offset field raises the invalid flag, is never taken, and produces the fall-through next PC.
- R9: Results appear on the outputs one rising clock edge after the inputs. While reset is asserted, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| br_type_i | input | 3 | Branch-family subtype |
| rx_i | input | 16 | Value of the named register |
| r0_i | input | 16 | Value of register zero |
| pc_i | input | 10 | Address of the branch instruction |
| off_i | input | 6 | Signed offset field |
| taken_o | output | 1 | Flow is redirected |
| next_pc_o | output | 10 | Address of the next instruction |
| bad_type_o | output | 1 | Malformed branch encoding |

## Verification
On every cycle, the assertions check the following against the inputs of the previous cycle: the register-jump target, the equality and signed-less-than decisions, the fall-through address for any not-taken result, and the rule that an invalid encoding never redirects. Only the bench's scenarios show the remaining behaviour. This covers the signed corners, such as the most negative register value and equal operands for the inclusive compares. It also covers wrap-around of a negative offset below address zero, fall-through from the last word of the code space, and the reset values.

// File: rtl/bru_pkg.sv
package bru_pkg;
  typedef enum logic [2:0] {
    BR_JR  = 3'd0,
    BR_EQ  = 3'd1,
    BR_NE  = 3'd2,
    BR_LT  = 3'd3,
    BR_GT  = 3'd4,
    BR_LE  = 3'd5,
    BR_GE  = 3'd6,
    BR_RSV = 3'd7
  } br_kind_e;
endpackage

// File: rtl/bru_cond.sv
module bru_cond
  import bru_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  br_kind_e            kind_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic                hit_o
);
  logic eq, lt;
  assign eq = (a_i == b_i);
  assign lt = ($signed(a_i) < $signed(b_i));

  always_comb begin
    unique case (kind_i)
      BR_EQ:   hit_o = eq;
      BR_NE:   hit_o = !eq;
      BR_LT:   hit_o = lt;
      BR_GT:   hit_o = !lt && !eq;
      BR_LE:   hit_o = lt || eq;
      BR_GE:   hit_o = !lt;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
  parameter int PC_W  = 10,
  parameter int OFF_W = 6
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [PC_W-1:0]  reg_addr_i,
  input  logic             is_jr_i,
  output logic [PC_W-1:0]  tgt_o,
  output logic [PC_W-1:0]  seq_o
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign seq_o   = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
  assign tgt_o   = is_jr_i ? reg_addr_i : (pc_i + off_ext);
endmodule

// File: rtl/bru_unit.sv
module bru_unit
  import bru_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 10,
  parameter int OFF_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        br_type_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic [DATA_W-1:0] r0_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              taken_o,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              bad_type_o
);
  br_kind_e        kind;
  logic            hit, is_jr, bad, take;
  logic [PC_W-1:0] tgt, seq, nxt;

  assign kind  = br_kind_e'(br_type_i);
  assign is_jr = (kind == BR_JR);
  // jump must carry a zero offset field; reserved subtype never redirects
  assign bad   = (kind == BR_RSV) || (is_jr && (off_i != '0));
  assign take  = !bad && (is_jr || hit);
  assign nxt   = take ? tgt : seq;

  bru_cond #(.DATA_W(DATA_W)) u_cond (
    .kind_i (kind),
    .a_i    (rx_i),
    .b_i    (r0_i),
    .hit_o  (hit)
  );

  bru_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i       (pc_i),
    .off_i      (off_i),
    .reg_addr_i (rx_i[PC_W-1:0]),
    .is_jr_i    (is_jr),
    .tgt_o      (tgt),
    .seq_o      (seq)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o    <= 1'b0;
      next_pc_o  <= '0;
      bad_type_o <= 1'b0;
    end else begin
      taken_o    <= take;
      next_pc_o  <= nxt;
      bad_type_o <= bad;
    end
  end
endmodule

// File: rtl/bru_unit_chk.sv
module bru_unit_chk #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 10,
  parameter int OFF_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        br_type_i,
  input logic [DATA_W-1:0] rx_i,
  input logic [DATA_W-1:0] r0_i,
  input logic [PC_W-1:0]   pc_i,
  input logic [OFF_W-1:0]  off_i,
  input logic              taken_o,
  input logic [PC_W-1:0]   next_pc_o,
  input logic              bad_type_o
);
  logic [PC_W-1:0] pc_inc;
  logic            jr_ok, is_eq, is_lt, is_rsv;
  assign pc_inc = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
  assign jr_ok  = (br_type_i == 3'd0) && (off_i == '0);
  assign is_eq  = (br_type_i == 3'd1);
  assign is_lt  = (br_type_i == 3'd3);
  assign is_rsv = (br_type_i == 3'd7);

  // R1
  jr_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && jr_ok) |-> (taken_o && next_pc_o == $past(rx_i[PC_W-1:0])));

  // R2
  beq_decide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && is_eq) |-> (taken_o == $past(rx_i == r0_i)));

  // R3
  blt_signed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && is_lt) |-> (taken_o == $past($signed(rx_i) < $signed(r0_i))));

  // R6
  fall_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !taken_o) |-> (next_pc_o == $past(pc_inc)));

  // R7
  rsv_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && is_rsv) |-> (bad_type_o && !taken_o));

  // R8
  bad_never_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_type_o |-> !taken_o);
endmodule

bind bru_unit bru_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .OFF_W(OFF_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .br_type_i  (br_type_i),
  .rx_i       (rx_i),
  .r0_i       (r0_i),
  .pc_i       (pc_i),
  .off_i      (off_i),
  .taken_o    (taken_o),
  .next_pc_o  (next_pc_o),
  .bad_type_o (bad_type_o)
);

// File: tb/bru_unit_tb.sv
`timescale 1ns/1ps
module bru_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  br_type_i = '0;
  logic [15:0] rx_i = '0;
  logic [15:0] r0_i = '0;
  logic [9:0]  pc_i = '0;
  logic [5:0]  off_i = '0;
  logic        taken_o;
  logic [9:0]  next_pc_o;
  logic        bad_type_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bru_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .br_type_i(br_type_i), .rx_i(rx_i),
    .r0_i(r0_i), .pc_i(pc_i), .off_i(off_i), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .bad_type_o(bad_type_o)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample 1 ns later
  task automatic run(string req, logic [2:0] t, logic [15:0] rx, logic [15:0] r0,
                     logic [9:0] pc, logic [5:0] off,
                     bit e_taken, int e_pc, bit e_bad);
    @(negedge clk_i);
    br_type_i = t; rx_i = rx; r0_i = r0; pc_i = pc; off_i = off;
    @(posedge clk_i);
    #1;
    chk({req, " taken"}, int'(taken_o), int'(e_taken));
    chk({req, " next_pc"}, int'(next_pc_o), e_pc);
    chk({req, " invalid"}, int'(bad_type_o), int'(e_bad));
  endtask

  task automatic t_reset();
    #1;
    chk("R9 reset taken", int'(taken_o), 0);
    chk("R9 reset next_pc", int'(next_pc_o), 0);
    chk("R9 reset invalid", int'(bad_type_o), 0);
  endtask

  task automatic t_jump();
    run("R1 jr", 3'd0, 16'hF123, 16'h0, 10'd5, 6'd0, 1, 10'h123, 0);
    run("R8 jr nonzero off", 3'd0, 16'h0040, 16'h0, 10'd5, 6'd3, 0, 6, 1);
  endtask

  task automatic t_equal();
    run("R2 beq eq", 3'd1, 16'd7, 16'd7, 10'd100, 6'd4, 1, 104, 0);
    run("R2 beq ne", 3'd1, 16'd7, 16'd8, 10'd100, 6'd4, 0, 101, 0);
    run("R2 bne ne", 3'd2, 16'hFFFF, 16'h0001, 10'd100, 6'h3C, 1, 96, 0);
    run("R2 bne eq", 3'd2, 16'h1234, 16'h1234, 10'd100, 6'h3C, 0, 101, 0);
  endtask

  task automatic t_order();
    run("R3 blt signed", 3'd3, 16'h8000, 16'd1, 10'd50, 6'd31, 1, 81, 0);
    run("R3 blt no", 3'd3, 16'd1, 16'h8000, 10'd50, 6'd31, 0, 51, 0);
    run("R3 bgt signed", 3'd4, 16'd0, 16'hFFFF, 10'd50, 6'd2, 1, 52, 0);
    run("R3 bgt eq", 3'd4, 16'd9, 16'd9, 10'd50, 6'd2, 0, 51, 0);
    run("R4 ble eq", 3'd5, 16'd9, 16'd9, 10'd10, 6'd1, 1, 11, 0);
    run("R4 ble gt", 3'd5, 16'h7FFF, 16'h8000, 10'd10, 6'd1, 0, 11, 0);
    run("R4 bge eq", 3'd6, 16'hFFF0, 16'hFFF0, 10'd10, 6'd3, 1, 13, 0);
    run("R4 bge lt", 3'd6, 16'hFFEF, 16'hFFF0, 10'd10, 6'd3, 0, 11, 0);
  endtask

  task automatic t_wrap();
    run("R5 neg offset wrap", 3'd1, 16'd0, 16'd0, 10'd2, 6'h3B, 1, 1021, 0);
    run("R5 min offset", 3'd1, 16'd0, 16'd0, 10'd40, 6'h20, 1, 8, 0);
    run("R5 pos offset wrap", 3'd1, 16'd0, 16'd0, 10'd1020, 6'd10, 1, 6, 0);
    run("R6 fall-through wrap", 3'd2, 16'd0, 16'd0, 10'd1023, 6'd5, 0, 0, 0);
  endtask

  task automatic t_reserved();
    run("R7 reserved", 3'd7, 16'd3, 16'd3, 10'd200, 6'd4, 0, 201, 1);
  endtask

  initial begin
    t_reset();
    #12 rst_ni = 1'b1;
    t_jump();
    t_equal();
    t_order();
    t_wrap();
    t_reserved();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule